// File: doc/BRIEF.md
# Cache-Line Atomic Swap Unit

This block performs single-operation atomic updates on one cache line of byte storage. A requester presents an operation carrying a byte offset, an operand width in bytes, a new value, a compare value and a conditional flag. The unit reads the addressed bytes, decides whether they may be replaced, writes the new value when allowed and returns the bytes it found. The conditional form replaces the bytes only when they equal the compare value. The unconditional form always replaces them.

The line lives in an internal register array that a byte-wide fill port loads. Results come back one clock after the operation is presented: a one-cycle `done` pulse, a `wrote` flag saying whether the line changed, an `err` flag for illegal requests, and the prior contents. Values are little-endian. The byte at the offset is the least significant byte of every operand and result.

Top module: `line_swap_unit`

## Requirements
- R1: After a synchronous active-low reset, `done`, `wrote` and `err` are 0 and every byte of the line reads as zero.
- R2: An operation presented with `op_valid` high produces `done` high for exactly one cycle, in the cycle after the operation is presented. `done` is low in any cycle that does not follow an operation.
- R3: An unconditional operation (`op_cond`=0) whose `op_size` is 1, 2, 4 or 8 and whose offset is a multiple of that size writes the low `op_size` bytes of `op_new` and sets `wrote`=1, `err`=0.
- R4: For every legal operation, `old_data` holds the addressed bytes as they were before the operation. The byte at the offset is placed in bits [7:0], the following bytes go in order into the bytes above it, and the bits above `op_size` bytes are zero. This holds whether or not a write takes place.
- R5: A conditional operation (`op_cond`=1) with `op_size`=8 compares all 64 bits of `op_cmp` with the addressed bytes. It writes, with `wrote`=1, only when they are equal.
- R6: A conditional operation with `op_size`=4 compares only `op_cmp[31:0]` with the addressed bytes. `op_cmp[63:32]` has no effect on the outcome.
- R7: A legal conditional operation whose compare fails gives `wrote`=0 and `err`=0, and it leaves the line unchanged.
- R8: A conditional operation with an `op_size` other than 4 or 8 gives `err`=1 and `wrote`=0, leaves the line unchanged, and returns `old_data`=0.
- R9: An unconditional operation with `op_size` of 0, 3, 5, 6, 7 or greater than 8 gives `err`=1 and `wrote`=0, leaves the line unchanged, and returns `old_data`=0.
- R10: An operation whose offset is not a multiple of `op_size` gives `err`=1 and `wrote`=0, leaves the line unchanged, and returns `old_data`=0.
- R11: A write changes only the `op_size` bytes starting at the offset. Every other byte of the line keeps its value.
- R12: When `op_valid` is low and `fill_en` is high, the fill port writes `fill_data` into the byte at `fill_idx`. When `op_valid` is high in the same cycle, the fill request is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fill_en | input | 1 | Fill port byte write strobe |
| fill_idx | input | OFFS_W | Byte index for the fill write |
| fill_data | input | 8 | Byte written by the fill port |
| op_valid | input | 1 | Operation present this cycle |
| op_cond | input | 1 | 1 = compare-and-swap, 0 = unconditional swap |
| op_offset | input | OFFS_W | Byte offset of the operand in the line |
| op_size | input | 4 | Operand width in bytes |
| op_new | input | 64 | Value to store |
| op_cmp | input | 64 | Compare value for the conditional form |
| done | output | 1 | One-cycle completion pulse |
| wrote | output | 1 | The line was updated by the completed operation |
| err | output | 1 | The completed operation was illegal |
| old_data | output | 64 | Prior contents of the addressed bytes |

## Verification
The hardest case to reach from the ports is a compare that fails or a request that is rejected and still leaves the line untouched. This includes failed compares that differ from the stored bytes only in their upper half. Such an outcome is visible only through later reads. The stimulus therefore sweeps every offset, every size from 0 to 9 and both forms. Each conditional operation is paired with a compare built from the model's current contents: an exact match whose upper half carries unrelated bits, then a match with one bit flipped. Later operations return old bytes, and two full-width reads at the end compare the whole line with the model. Together they expose any stray or missing write.

// File: rtl/swp_pkg.sv
// Package: shared constants and types for the cache-line swap unit.
// Assumes operands never exceed 8 bytes.
package swp_pkg;
    localparam int MAX_OP_BYTES = 8;
    localparam int OP_W         = MAX_OP_BYTES * 8;
    typedef logic [OP_W-1:0] opword_t;
endpackage

// File: rtl/swp_access_check.sv
// Module: swp_access_check
// Decides whether an operation is legal from its form, size and offset.
// Assumes LINE_BYTES is a multiple of 8, so aligned operands fit in the line.
module swp_access_check #(
    parameter int LINE_BYTES = 16,
    localparam int OFFS_W    = $clog2(LINE_BYTES)
) (
    input  logic              cond_i,
    input  logic [3:0]        size_i,
    input  logic [OFFS_W-1:0] offset_i,
    output logic              legal_o
);
    logic size_pow2;
    logic size_cond_ok;
    logic aligned;
    logic in_line;

    // Purpose: classify the size, the alignment and the range of the operand.
    always_comb begin
        size_pow2    = (size_i == 4'd1) || (size_i == 4'd2) ||
                       (size_i == 4'd4) || (size_i == 4'd8);
        size_cond_ok = !cond_i || (size_i == 4'd4) || (size_i == 4'd8);
        aligned      = size_pow2 &&
                       ((int'(offset_i) & (int'(size_i) - 1)) == 0);
        in_line      = (int'(offset_i) + int'(size_i)) <= LINE_BYTES;
        legal_o      = size_pow2 && size_cond_ok && aligned && in_line;
    end
endmodule

// File: rtl/swp_lane_select.sv
// Module: swp_lane_select
// Extracts the addressed bytes of the line as a little-endian operand.
// Bytes beyond the operand size read as zero.
module swp_lane_select
    import swp_pkg::*;
#(
    parameter int LINE_BYTES = 16,
    localparam int OFFS_W    = $clog2(LINE_BYTES),
    localparam int LINE_W    = LINE_BYTES * 8
) (
    input  logic [LINE_W-1:0] line_i,
    input  logic [OFFS_W-1:0] offset_i,
    input  logic [3:0]        size_i,
    output opword_t           value_o
);
    // Purpose: gather up to MAX_OP_BYTES bytes starting at the offset.
    always_comb begin
        value_o = '0;
        for (int k = 0; k < MAX_OP_BYTES; k++) begin
            if (k < int'(size_i) && (int'(offset_i) + k) < LINE_BYTES) begin
                value_o[k*8 +: 8] = line_i[(int'(offset_i) + k)*8 +: 8];
            end
        end
    end
endmodule

// File: rtl/swp_line_store.sv
// Module: swp_line_store
// Byte-addressable register array that holds one cache line.
// An update mask from the swap path takes priority over the fill port.
// The caller gates fill_we when both would write.
module swp_line_store #(
    parameter int LINE_BYTES = 16,
    localparam int OFFS_W    = $clog2(LINE_BYTES),
    localparam int LINE_W    = LINE_BYTES * 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  fill_we,
    input  logic [OFFS_W-1:0]     fill_idx,
    input  logic [7:0]            fill_data,
    input  logic [LINE_BYTES-1:0] upd_mask,
    input  logic [LINE_W-1:0]     upd_bytes,
    output logic [LINE_W-1:0]     line_o
);
    for (genvar j = 0; j < LINE_BYTES; j++) begin : g_byte
        // Purpose: hold byte j; clear on reset, then take a swap update or a fill.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                line_o[j*8 +: 8] <= 8'h00;
            end else if (upd_mask[j]) begin
                line_o[j*8 +: 8] <= upd_bytes[j*8 +: 8];
            end else if (fill_we && (int'(fill_idx) == j)) begin
                line_o[j*8 +: 8] <= fill_data;
            end
        end
    end
endmodule

// File: rtl/line_swap_unit.sv
// Module: line_swap_unit
// Performs an atomic swap or a compare-and-swap on one cache line.
// An operation is taken whenever op_valid is high.
// Results are registered and appear with a one-cycle done pulse.
// Assumes no back-pressure: the requester accepts every result.
module line_swap_unit
    import swp_pkg::*;
#(
    parameter int LINE_BYTES = 16,
    localparam int OFFS_W    = $clog2(LINE_BYTES),
    localparam int LINE_W    = LINE_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_en,
    input  logic [OFFS_W-1:0] fill_idx,
    input  logic [7:0]        fill_data,
    input  logic              op_valid,
    input  logic              op_cond,
    input  logic [OFFS_W-1:0] op_offset,
    input  logic [3:0]        op_size,
    input  logic [OP_W-1:0]   op_new,
    input  logic [OP_W-1:0]   op_cmp,
    output logic              done,
    output logic              wrote,
    output logic              err,
    output logic [OP_W-1:0]   old_data
);
    logic [LINE_W-1:0]     line_flat;
    logic                  legal;
    opword_t               cur_val;
    logic                  match;
    logic                  do_write;
    logic [LINE_BYTES-1:0] upd_mask;
    logic [LINE_W-1:0]     upd_bytes;

    swp_access_check #(.LINE_BYTES(LINE_BYTES)) u_check (
        .cond_i   (op_cond),
        .size_i   (op_size),
        .offset_i (op_offset),
        .legal_o  (legal)
    );

    swp_lane_select #(.LINE_BYTES(LINE_BYTES)) u_select (
        .line_i   (line_flat),
        .offset_i (op_offset),
        .size_i   (op_size),
        .value_o  (cur_val)
    );

    // Purpose: evaluate the compare; a 4-byte compare ignores the upper half.
    always_comb begin
        if (!op_cond)
            match = 1'b1;
        else if (op_size == 4'd8)
            match = (cur_val == op_cmp);
        else
            match = (cur_val[31:0] == op_cmp[31:0]);
        do_write = op_valid && legal && match;
    end

    // Purpose: build the per-byte write mask and data for the addressed bytes.
    always_comb begin
        upd_mask  = '0;
        upd_bytes = '0;
        for (int j = 0; j < LINE_BYTES; j++) begin
            if (do_write && j >= int'(op_offset) &&
                j < int'(op_offset) + int'(op_size) &&
                (j - int'(op_offset)) < MAX_OP_BYTES) begin
                upd_mask[j]        = 1'b1;
                upd_bytes[j*8 +: 8] = op_new[(j - int'(op_offset))*8 +: 8];
            end
        end
    end

    swp_line_store #(.LINE_BYTES(LINE_BYTES)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .fill_we   (fill_en && !op_valid),
        .fill_idx  (fill_idx),
        .fill_data (fill_data),
        .upd_mask  (upd_mask),
        .upd_bytes (upd_bytes),
        .line_o    (line_flat)
    );

    // Purpose: register the completion pulse, status flags and prior contents.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done     <= 1'b0;
            wrote    <= 1'b0;
            err      <= 1'b0;
            old_data <= '0;
        end else begin
            done  <= op_valid;
            wrote <= do_write;
            err   <= op_valid && !legal;
            if (op_valid)
                old_data <= legal ? cur_val : '0;
        end
    end
endmodule

// File: rtl/line_swap_unit_checker.sv
// Module: line_swap_unit_checker
// Temporal checks on the swap unit, attached to the top module by bind.
module line_swap_unit_checker #(
    parameter int LINE_BYTES = 16,
    localparam int OFFS_W    = $clog2(LINE_BYTES),
    localparam int LINE_W    = LINE_BYTES * 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic              op_cond,
    input logic [OFFS_W-1:0] op_offset,
    input logic [3:0]        op_size,
    input logic              done,
    input logic              wrote,
    input logic              err,
    input logic [LINE_W-1:0] line_flat
);
    logic pow2;
    assign pow2 = (op_size == 4'd1) || (op_size == 4'd2) ||
                  (op_size == 4'd4) || (op_size == 4'd8);

    a_r2_done_follows_op: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> done);
    a_r2_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !done);
    a_r8_error_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (done && !wrote));
    a_r8_cond_bad_size: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_cond && op_size != 4'd4 && op_size != 4'd8) |=> (err && !wrote));
    a_r9_zero_size: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_size == 4'd0) |=> err);
    a_r10_misaligned: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && pow2 && ((int'(op_offset) & (int'(op_size) - 1)) != 0)) |=> err);
    a_r7_line_kept_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !wrote) |-> $stable(line_flat));
endmodule

bind line_swap_unit line_swap_unit_checker #(.LINE_BYTES(LINE_BYTES)) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_cond   (op_cond),
    .op_offset (op_offset),
    .op_size   (op_size),
    .done      (done),
    .wrote     (wrote),
    .err       (err),
    .line_flat (line_flat)
);

// File: tb/tb_line_swap_unit.sv
// Bench for line_swap_unit: reset, a full sweep of offset x size x form,
// fill priority, and final line readback against a byte model.
module tb_line_swap_unit;
    localparam int LB = 16;
    localparam int OW = $clog2(LB);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fill_en = 1'b0;
    logic [OW-1:0] fill_idx = '0;
    logic [7:0]    fill_data = '0;
    logic          op_valid = 1'b0;
    logic          op_cond = 1'b0;
    logic [OW-1:0] op_offset = '0;
    logic [3:0]    op_size = '0;
    logic [63:0]   op_new = '0;
    logic [63:0]   op_cmp = '0;
    logic          done, wrote, err;
    logic [63:0]   old_data;

    int checks = 0;
    int errors = 0;
    logic [7:0]  model [LB];
    logic [63:0] seed = 64'h1234_5678_9ABC_DEF1;

    line_swap_unit #(.LINE_BYTES(LB)) dut (
        .clk(clk), .rst_n(rst_n), .fill_en(fill_en), .fill_idx(fill_idx),
        .fill_data(fill_data), .op_valid(op_valid), .op_cond(op_cond),
        .op_offset(op_offset), .op_size(op_size), .op_new(op_new),
        .op_cmp(op_cmp), .done(done), .wrote(wrote), .err(err),
        .old_data(old_data)
    );

    always #5 clk = ~clk;

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [63:0] model_read(input int off, input int sz);
        logic [63:0] v = '0;
        for (int k = 0; k < sz; k++) v[k*8 +: 8] = model[off + k];
        return v;
    endfunction

    function automatic logic [63:0] next_rand();
        seed = {seed[62:0], seed[63] ^ seed[62] ^ seed[60] ^ seed[59]};
        return seed ^ (seed << 17);
    endfunction

    // One operation: drive at a falling edge, check the registered result at the next.
    task automatic run_op(input logic c, input int off, input int sz,
                          input logic [63:0] nv, input logic [63:0] cv);
        logic legal, match, w;
        logic [63:0] exp_old;
        string etag;
        legal = (c ? (sz == 4 || sz == 8) : (sz == 1 || sz == 2 || sz == 4 || sz == 8))
                && (off % (sz == 0 ? 1 : sz) == 0) && (off + sz <= LB) && sz != 0;
        exp_old = legal ? model_read(off, sz) : 64'd0;
        if (!c) match = 1'b1;
        else if (sz == 8) match = (exp_old == cv);
        else match = (exp_old[31:0] == cv[31:0]);
        w = legal && match;
        if (c && !(sz == 4 || sz == 8)) etag = "R8";
        else if (!(sz == 1 || sz == 2 || sz == 4 || sz == 8)) etag = "R9";
        else etag = "R10";
        @(negedge clk);
        op_valid = 1'b1; op_cond = c; op_offset = OW'(off); op_size = 4'(sz);
        op_new = nv; op_cmp = cv;
        @(negedge clk);
        op_valid = 1'b0;
        check("R2 done", {63'd0, done}, 64'd1);
        check(legal ? "R3/R5/R6/R7 err" : etag, {63'd0, err}, {63'd0, !legal});
        check(!legal ? etag : (c ? (sz == 8 ? "R5 wrote" : "R6 wrote") : "R3 wrote"),
              {63'd0, wrote}, {63'd0, w});
        check(legal ? "R4 old_data" : etag, old_data, exp_old);
        if (w) for (int k = 0; k < sz; k++) model[off + k] = nv[k*8 +: 8];
    endtask

    // Watchdog: a hung run is counted as a failure and still reaches the summary.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < LB; i++) model[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state of flags and line
        check("R1 done", {63'd0, done}, 64'd0);
        check("R1 wrote", {63'd0, wrote}, 64'd0);
        check("R1 err", {63'd0, err}, 64'd0);
        run_op(1'b0, 0, 8, 64'd0, 64'd0);
        run_op(1'b0, 8, 8, 64'd0, 64'd0);
        // R2: done falls one cycle after the pulse
        @(negedge clk);
        check("R2 done drops", {63'd0, done}, 64'd0);

        // R12: fill port loads distinct bytes
        for (int i = 0; i < LB; i++) begin
            @(negedge clk);
            fill_en = 1'b1; fill_idx = OW'(i); fill_data = 8'(8'h11 * i + 8'h03);
            model[i] = 8'(8'h11 * i + 8'h03);
        end
        @(negedge clk);
        fill_en = 1'b0;

        // R12: fill ignored when an operation is present in the same cycle
        @(negedge clk);
        fill_en = 1'b1; fill_idx = OW'(3); fill_data = 8'hEE;
        op_valid = 1'b1; op_cond = 1'b0; op_offset = OW'(8); op_size = 4'd4;
        op_new = 64'hA5A5_A5A5; op_cmp = '0;
        @(negedge clk);
        fill_en = 1'b0; op_valid = 1'b0;
        for (int k = 0; k < 4; k++) model[8 + k] = 8'hA5;
        run_op(1'b0, 0, 4, model_read(0, 4), 64'd0);
        check("R12 fill ignored", {56'd0, old_data[31:24]}, {56'd0, model[3]});

        // R3-R11 sweep: every offset, sizes 0..9, both forms, match and mismatch
        for (int off = 0; off < LB; off++) begin
            for (int sz = 0; sz < 10; sz++) begin
                run_op(1'b0, off, sz, next_rand(), next_rand());
                begin
                    logic [63:0] cur;
                    cur = (off + sz <= LB && sz <= 8) ? model_read(off, sz) : 64'd0;
                    // R6: upper compare half carries unrelated bits
                    run_op(1'b1, off, sz, next_rand(),
                           (sz == 4) ? {32'hDEAD_BEEF, cur[31:0]} : cur);
                    // R7: single-bit mismatch
                    cur = (off + sz <= LB && sz <= 8) ? model_read(off, sz) : 64'd0;
                    run_op(1'b1, off, sz, next_rand(), cur ^ 64'd1);
                end
            end
        end

        // R11: whole-line readback against the model
        run_op(1'b0, 0, 8, 64'd0, 64'd0);
        run_op(1'b0, 8, 8, 64'd0, 64'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule